// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block carries a raw NAND flash bus through one complete operation. The host first loads a set of operation inputs: up to three command opcode bytes, a 16-bit column address, a 24-bit row address, a transfer length in bytes, and a 15-bit phase-select word. The host then pulses `start`. The block latches these inputs and walks through the selected bus phases in one fixed hardware order. It generates the command latch, address latch, write strobe and read strobe itself. It stalls on the flash ready line where told to, and it moves data between the flash and a word-wide page buffer through a byte-enabled buffer port. A sticky `done` flag marks the end of the operation.

The phase-select word contains no microcode. Each bit switches one bus phase on or off. Bits 14 down to 2 are visited in descending order, and every disabled phase is skipped with no bus activity. The common flash operations are therefore just fixed constants: page read 0x7EE0, page program 0x7FC0, block erase 0x4EC0, read ID 0x4804, reset 0x4040 and status read 0x4068. The strobe low and high widths are set per operation.

Top module: `nand_seq`

## Requirements
- R1: Phases run strictly from bit 14 down to bit 2 of `op_code`, and a phase whose bit is clear produces no strobe. The bit meanings are: 14 command byte A, 13/12 column bytes, 11/10/9 row bytes, 8 write data, 7 command byte B, 6 ready wait, 5 read data, 4 command byte C, 3 status read, 2 ID read.
- R2: Each address phase sends one byte with `nf_ale` high, in this order: bit 13 sends `op_col[7:0]`, bit 12 sends `op_col[15:8]`, bit 11 sends `op_row[7:0]`, bit 10 sends `op_row[15:8]` and bit 9 sends `op_row[23:16]`.
- R3: Command phases 14, 7 and 4 send `op_cmd_a`, `op_cmd_b` and `op_cmd_c` respectively, each on `nf_dq_out[7:0]` with `nf_cle` high. `nf_cle` and `nf_ale` are never both high.
- R4: The write-data phase sends `op_len` bytes taken from the buffer starting at byte 0. Byte n lives in word n/4 at bits [31-8*(n%4) -: 8], so the first byte of a word comes from bits 31:24.
- R5: The read-data phase stores `op_len` bytes from the flash into the buffer starting at byte 0, in the same big-endian layout. Each capture sets only the byte enables of the bytes it writes (`buf_be[3]` selects bits 31:24), so other bytes of the word keep their values.
- R6: With `wide_bus` high, each write-data or read-data strobe moves two bytes, the earlier byte on `nf_dq[7:0]` and the later one on `nf_dq[15:8]`. Command, address, status and ID cycles are always byte-wide, and `nf_dq_out[15:8]` is zero during them.
- R7: The ready-wait phase waits `RB_GUARD` clocks, then holds the sequence until `nf_rb` is high. It produces no strobes.
- R8: The status phase reads one byte and the ID phase reads `ID_BYTES` bytes. Both are byte-wide and both store into the buffer from byte 0.
- R9: Each strobe stays low for `t_lo`+1 clocks. Between strobes of one data phase the strobe stays high for `t_hi`+1 clocks. `nf_cle`/`nf_ale` rise one clock before the strobe falls and do not change at either strobe edge.
- R10: A `start` pulse while `busy` is high is ignored. The running operation finishes unchanged and no further operation follows.
- R11: `done` sets when an operation ends and stays set until a `done_clr` pulse clears it.
- R12: An `op_code` with bits 14..2 all zero sets `done` on the clock that accepts `start`, never raises `busy`, and produces no bus cycle.
- R13: After reset `busy` and `done` are low, both strobes are high, `nf_cle`, `nf_ale` and `nf_dq_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-clock pulse that launches an operation |
| op_code | input | 15 | Phase-select word (bits 14..2 used) |
| op_cmd_a | input | 8 | Command byte for phase 14 |
| op_cmd_b | input | 8 | Command byte for phase 7 |
| op_cmd_c | input | 8 | Command byte for phase 4 |
| op_col | input | 16 | Column address |
| op_row | input | 24 | Row address |
| op_len | input | LW | Data transfer length in bytes |
| wide_bus | input | 1 | 1 = 16-bit data cycles, 0 = 8-bit |
| t_lo | input | TW | Strobe low width minus one |
| t_hi | input | TW | Strobe high width minus one |
| done_clr | input | 1 | Clears `done` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Sticky completion flag |
| buf_addr | output | LW-2 | Buffer word address |
| buf_rdata | input | 32 | Buffer read data for `buf_addr`, same cycle |
| buf_wdata | output | 32 | Buffer write data |
| buf_be | output | 4 | Buffer byte enables |
| buf_we | output | 1 | Buffer write strobe |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 16 | Flash data out |
| nf_dq_oe | output | 1 | Flash data output enable |
| nf_dq_in | input | 16 | Flash data in |
| nf_rb | input | 1 | Flash ready (high) / busy (low) |

## Verification
The assertions assume the following about the inputs:
- `start` and `done_clr` are single-clock pulses.
- `op_len` fits in the buffer.
- `op_len` is even whenever `wide_bus` is set.
- The buffer returns read data in the same cycle it is addressed.

The stimulus keeps to these rules. It drives every input on the falling clock edge, uses only even lengths in 16-bit mode, and models the buffer as a combinationally read array. A small flash model logs every write strobe together with its latch flags and data. It also feeds the read strobes a known byte ramp, so the expected bus traces and buffer words can be worked out ahead of each scenario.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int MAX_BYTES = 2304,
  parameter int ID_BYTES  = 5,
  parameter int RB_GUARD  = 4,
  parameter int TW        = 4,
  localparam int LW = $clog2(MAX_BYTES + 1),
  localparam int GW = $clog2(RB_GUARD + 2),
  localparam int CW = (GW > TW) ? GW : TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [14:0]   op_code,
  input  logic [7:0]    op_cmd_a,
  input  logic [7:0]    op_cmd_b,
  input  logic [7:0]    op_cmd_c,
  input  logic [15:0]   op_col,
  input  logic [23:0]   op_row,
  input  logic [LW-1:0] op_len,
  input  logic          wide_bus,
  input  logic [TW-1:0] t_lo,
  input  logic [TW-1:0] t_hi,
  input  logic          done_clr,
  output logic          busy,
  output logic          done,
  output logic [LW-3:0] buf_addr,
  input  logic [31:0]   buf_rdata,
  output logic [31:0]   buf_wdata,
  output logic [3:0]    buf_be,
  output logic          buf_we,
  output logic          nf_cle,
  output logic          nf_ale,
  output logic          nf_we_n,
  output logic          nf_re_n,
  output logic [15:0]   nf_dq_out,
  output logic          nf_dq_oe,
  input  logic [15:0]   nf_dq_in,
  input  logic          nf_rb
);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_SETUP, S_LO, S_HI, S_WAIT} st_t;

  st_t          st;
  logic [3:0]   ph;
  logic [LW-1:0] cnt, len_q, need, step;
  logic [CW-1:0] tcnt;
  logic [14:0]  code_q;
  logic [7:0]   ca_q, cb_q, cc_q, abyte;
  logic [15:0]  col_q;
  logic [23:0]  row_q;
  logic         wide_q;
  logic [TW-1:0] lo_q, hi_q;

  wire is_cmd  = (ph == 4'd14) || (ph == 4'd7) || (ph == 4'd4);
  wire is_addr = (ph >= 4'd9) && (ph <= 4'd13);
  wire is_wr   = (ph == 4'd8);
  wire is_in   = (ph == 4'd5) || (ph == 4'd3) || (ph == 4'd2);
  wire is_out  = is_cmd || is_addr || is_wr;
  wire dbl     = wide_q && (is_wr || ph == 4'd5);
  wire active  = (st == S_SETUP) || (st == S_LO) || (st == S_HI);
  wire [1:0] lane = cnt[1:0];
  wire [31:0] rsh = buf_rdata << {lane, 3'b000};
  wire last_lo = (st == S_LO) && (tcnt == CW'(lo_q));
  wire [LW:0] nxt = {1'b0, cnt} + {1'b0, step};

  assign step = dbl ? LW'(2) : LW'(1);

  always_comb begin
    case (ph)
      4'd8, 4'd5: need = len_q;
      4'd2:       need = LW'(ID_BYTES);
      default:    need = LW'(1);
    endcase
    case (ph)
      4'd14:   abyte = ca_q;
      4'd7:    abyte = cb_q;
      4'd4:    abyte = cc_q;
      4'd13:   abyte = col_q[7:0];
      4'd12:   abyte = col_q[15:8];
      4'd11:   abyte = row_q[7:0];
      4'd10:   abyte = row_q[15:8];
      4'd9:    abyte = row_q[23:16];
      default: abyte = 8'h00;
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign nf_cle    = active && is_cmd;
  assign nf_ale    = active && is_addr;
  assign nf_we_n   = !((st == S_LO) && is_out);
  assign nf_re_n   = !((st == S_LO) && is_in);
  assign nf_dq_oe  = active && is_out;
  assign nf_dq_out = !(active && is_out) ? 16'h0000 :
                     is_wr ? (dbl ? {rsh[23:16], rsh[31:24]} : {8'h00, rsh[31:24]}) :
                     {8'h00, abyte};
  assign buf_addr  = cnt[LW-1:2];
  assign buf_we    = last_lo && is_in;
  assign buf_be    = (dbl ? 4'b1100 : 4'b1000) >> lane;
  assign buf_wdata = (dbl ? {nf_dq_in[7:0], nf_dq_in[15:8], 16'h0000}
                          : {nf_dq_in[7:0], 24'h000000}) >> {lane, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 4'd0; cnt <= '0; tcnt <= '0; done <= 1'b0;
      code_q <= '0; ca_q <= '0; cb_q <= '0; cc_q <= '0; col_q <= '0;
      row_q <= '0; len_q <= '0; wide_q <= 1'b0; lo_q <= '0; hi_q <= '0;
    end else begin
      if (done_clr) done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          code_q <= op_code; ca_q <= op_cmd_a; cb_q <= op_cmd_b; cc_q <= op_cmd_c;
          col_q <= op_col; row_q <= op_row; len_q <= op_len; wide_q <= wide_bus;
          lo_q <= t_lo; hi_q <= t_hi; cnt <= '0; ph <= 4'd14;
          if (op_code[14:2] == 13'd0) done <= 1'b1;
          else st <= S_SCAN;
        end
        S_SCAN: begin
          tcnt <= '0;
          if (ph < 4'd2) begin
            st <= S_IDLE; done <= 1'b1;
          end else if (!code_q[ph] || need == '0) ph <= ph - 4'd1;
          else if (ph == 4'd6) st <= S_WAIT;
          else st <= S_SETUP;
        end
        S_SETUP: st <= S_LO;
        S_LO: begin
          if (tcnt == CW'(lo_q)) begin st <= S_HI; tcnt <= '0; end
          else tcnt <= tcnt + 1'b1;
        end
        S_HI: begin
          if (tcnt == CW'(hi_q)) begin
            tcnt <= '0;
            if (nxt >= {1'b0, need}) begin
              cnt <= '0; ph <= ph - 4'd1; st <= S_SCAN;
            end else begin
              cnt <= nxt[LW-1:0]; st <= S_LO;
            end
          end else tcnt <= tcnt + 1'b1;
        end
        S_WAIT: begin
          if (tcnt < CW'(RB_GUARD)) tcnt <= tcnt + 1'b1;
          else if (nf_rb) begin ph <= ph - 4'd1; st <= S_SCAN; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic done_clr,
  input logic buf_we,
  input logic nf_cle,
  input logic nf_ale,
  input logic nf_we_n,
  input logic nf_re_n,
  input logic nf_dq_oe
);

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(nf_cle && nf_ale)); // R3

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) nf_we_n || nf_re_n); // R9

  AST_LATCH_STABLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nf_we_n) |-> $stable(nf_cle) && $stable(nf_ale)); // R9

  AST_LATCH_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_we_n) |-> $stable(nf_cle) && $stable(nf_ale)); // R9

  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) !nf_we_n |-> nf_dq_oe); // R4

  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) !nf_re_n |-> !nf_dq_oe); // R5

  AST_CAPTURE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n) buf_we |-> !nf_re_n); // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done && !done_clr |=> done); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_dq_oe); // R12

endmodule

bind nand_seq nand_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .done_clr(done_clr),
  .buf_we(buf_we), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
  .nf_re_n(nf_re_n), .nf_dq_oe(nf_dq_oe)
);

// File: tb/nand_seq_bench.sv
`timescale 1ns/1ps
module nand_seq_bench;
  localparam int LW = 12;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, done_clr = 1'b0, wide_bus = 1'b0, nf_rb = 1'b1;
  logic [14:0] op_code = '0;
  logic [7:0] op_cmd_a = '0, op_cmd_b = '0, op_cmd_c = '0;
  logic [15:0] op_col = '0;
  logic [23:0] op_row = '0;
  logic [LW-1:0] op_len = '0;
  logic [3:0] t_lo = 4'd1, t_hi = 4'd1;
  logic busy, done, buf_we, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [LW-3:0] buf_addr;
  logic [31:0] buf_rdata, buf_wdata;
  logic [3:0] buf_be;
  logic [15:0] nf_dq_out, nf_dq_in;

  int checks = 0, errors = 0;
  logic [31:0] mem [0:575];
  logic [31:0] lg [0:63];
  int nlog = 0, rd_idx = 0, cyc = 0;
  int t_fall = 0, t_rise = 0, t_cle = 0, lo_w = 0, hi_w = 0, setup_w = 0;
  logic wide_tb = 1'b0;

  nand_seq u_nand_seq (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  function automatic logic [7:0] pat(input int k);
    return 8'(8'hA0 + k);
  endfunction

  assign nf_dq_in  = wide_tb ? {pat(2*rd_idx+1), pat(2*rd_idx)} : {8'h00, pat(rd_idx)};
  assign buf_rdata = mem[buf_addr];

  always @(posedge clk)
    if (buf_we)
      for (int i = 0; i < 4; i++)
        if (buf_be[i]) mem[buf_addr][8*i +: 8] <= buf_wdata[8*i +: 8];

  always @(posedge nf_re_n) if (rst_n) rd_idx = rd_idx + 1;
  always @(posedge nf_cle) t_cle = cyc;
  always @(negedge nf_we_n) begin
    t_fall = cyc; hi_w = cyc - t_rise;
    if (nf_cle) setup_w = cyc - t_cle;
  end
  always @(posedge nf_we_n) if (rst_n) begin
    lo_w = cyc - t_fall; t_rise = cyc;
    if (nlog < 64) begin lg[nlog] = {14'd0, nf_cle, nf_ale, nf_dq_out}; nlog = nlog + 1; end
  end

  function automatic logic [31:0] ev(input logic c, input logic a, input logic [15:0] d);
    return {14'd0, c, a, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [14:0] c, input logic [7:0] a, b, cc,
                        input logic [15:0] col, input logic [23:0] row, input int len);
    @(negedge clk);
    nlog = 0; rd_idx = 0;
    op_code = c; op_cmd_a = a; op_cmd_b = b; op_cmd_c = cc;
    op_col = col; op_row = row; op_len = LW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_op(input string req);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(req, {31'd0, done}, 32'd1);
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  task automatic t_reset_state;
    chk("R13 busy", {31'd0, busy}, 32'd0);
    chk("R13 done", {31'd0, done}, 32'd0);
    chk("R13 pins", {27'd0, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe}, 32'b11000);
  endtask

  task automatic t_three_cmds;
    launch(15'h4090, 8'h11, 8'h22, 8'h33, 16'h0, 24'h0, 0);
    finish_op("R1 done");
    chk("R1 count", nlog, 3);
    chk("R3 cmd A", lg[0], ev(1, 0, 16'h0011));
    chk("R3 cmd B", lg[1], ev(1, 0, 16'h0022));
    chk("R3 cmd C", lg[2], ev(1, 0, 16'h0033));
  endtask

  task automatic t_program;
    mem[0] = 32'h11223344; mem[1] = 32'h55667788;
    launch(15'h7FC0, 8'h80, 8'h10, 8'h00, 16'h0000, 24'h000102, 6);
    finish_op("R4 done");
    chk("R1 count", nlog, 13);
    chk("R3 first cmd", lg[0], ev(1, 0, 16'h0080));
    chk("R2 col lo", lg[1], ev(0, 1, 16'h0000));
    chk("R2 row lo", lg[3], ev(0, 1, 16'h0002));
    chk("R2 row mid", lg[4], ev(0, 1, 16'h0001));
    for (int i = 0; i < 6; i++)
      chk("R4 data", lg[6+i], ev(0, 0, {8'h00, 8'(8'h11 * (i + 1))}));
    chk("R1 last cmd", lg[12], ev(1, 0, 16'h0010));
  endtask

  task automatic t_read;
    mem[0] = 32'h0; mem[1] = 32'h11111111;
    launch(15'h7EE0, 8'h00, 8'h30, 8'h00, 16'h0834, 24'h012345, 7);
    finish_op("R5 done");
    chk("R1 count", nlog, 7);
    chk("R2 col hi", lg[2], ev(0, 1, 16'h0008));
    chk("R2 row top", lg[5], ev(0, 1, 16'h0001));
    chk("R5 word0", mem[0], 32'hA0A1A2A3);
    chk("R5 word1 partial", mem[1], 32'hA4A5A611);
  endtask

  task automatic t_erase_wait;
    nf_rb = 1'b0;
    launch(15'h4EC0, 8'h60, 8'hD0, 8'h00, 16'h0, 24'hABCDEF, 0);
    repeat (80) @(negedge clk);
    chk("R7 held busy", {30'd0, busy, done}, 32'b10);
    chk("R7 cmds before wait", nlog, 5);
    chk("R2 erase row", lg[1], ev(0, 1, 16'h00EF));
    chk("R3 confirm", lg[4], ev(1, 0, 16'h00D0));
    nf_rb = 1'b1;
    finish_op("R7 release");
    chk("R7 no extra cycles", nlog, 5);
  endtask

  task automatic t_wide;
    wide_bus = 1'b1; wide_tb = 1'b1;
    mem[0] = 32'h11223344;
    launch(15'h4100, 8'h80, 8'h00, 8'h00, 16'h0, 24'h0, 4);
    finish_op("R6 program");
    chk("R6 count", nlog, 3);
    chk("R6 cmd narrow", lg[0], ev(1, 0, 16'h0080));
    chk("R6 data0", lg[1], ev(0, 0, 16'h2211));
    chk("R6 data1", lg[2], ev(0, 0, 16'h4433));
    mem[0] = 32'h0;
    launch(15'h4020, 8'h00, 8'h00, 8'h00, 16'h0, 24'h0, 4);
    finish_op("R6 read");
    chk("R6 read pulses", rd_idx, 2);
    chk("R6 read word", mem[0], 32'hA0A1A2A3);
    mem[0] = 32'h12345678;
    launch(15'h4068, 8'h70, 8'h00, 8'h00, 16'h0, 24'h0, 0);
    finish_op("R8 status");
    chk("R8 status cmd", lg[0], ev(1, 0, 16'h0070));
    chk("R8 status byte", mem[0], 32'hA0345678);
    wide_bus = 1'b0; wide_tb = 1'b0;
  endtask

  task automatic t_read_id;
    mem[0] = 32'h0; mem[1] = 32'h0;
    launch(15'h4804, 8'h90, 8'h00, 8'h00, 16'h0000, 24'h0, 0);
    finish_op("R8 id");
    chk("R8 id log", nlog, 2);
    chk("R8 id addr", lg[1], ev(0, 1, 16'h0000));
    chk("R8 id word0", mem[0], 32'hA0A1A2A3);
    chk("R8 id word1", mem[1], 32'hA4000000);
  endtask

  task automatic t_timing;
    t_lo = 4'd3; t_hi = 4'd2;
    mem[0] = 32'h0;
    launch(15'h4100, 8'h80, 8'h00, 8'h00, 16'h0, 24'h0, 2);
    finish_op("R9 done");
    chk("R9 low width", lo_w, 4);
    chk("R9 high width", hi_w, 3);
    chk("R9 latch setup", setup_w, 1);
    t_lo = 4'd1; t_hi = 4'd1;
  endtask

  task automatic t_start_busy;
    nf_rb = 1'b0;
    launch(15'h40C0, 8'h01, 8'h02, 8'h00, 16'h0, 24'h0, 0);
    repeat (20) @(negedge clk);
    op_code = 15'h4040; op_cmd_a = 8'hEE; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    nf_rb = 1'b1;
    finish_op("R10 done");
    repeat (30) @(negedge clk);
    chk("R10 busy after", {31'd0, busy}, 32'd0);
    chk("R10 count", nlog, 2);
    chk("R10 first cmd", lg[0], ev(1, 0, 16'h0001));
  endtask

  task automatic t_done_sticky;
    launch(15'h4040, 8'hFF, 8'h00, 8'h00, 16'h0, 24'h0, 0);
    repeat (40) @(negedge clk);
    chk("R11 still set", {31'd0, done}, 32'd1);
    done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    chk("R11 cleared", {31'd0, done}, 32'd0);
  endtask

  task automatic t_zero;
    launch(15'h0000, 8'h55, 8'h00, 8'h00, 16'h0, 24'h0, 0);
    chk("R12 done at once", {30'd0, busy, done}, 32'b01);
    repeat (20) @(negedge clk);
    chk("R12 no cycles", nlog, 0);
    done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 576; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset_state;
    rst_n = 1'b1;
    @(negedge clk);
    t_three_cmds;
    t_program;
    t_read;
    t_erase_wait;
    t_wide;
    t_read_id;
    t_timing;
    t_start_busy;
    t_done_sticky;
    t_zero;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule